// File: doc/BRIEF.md
# Serial Command Receiver for a Multichannel Converter

This block is the slave-side input stage of a multichannel converter's serial port. A host sends 16-bit command words, most significant bit first, framed in one of two ways. In chip-select framing the frame opens when the active-low select falls while the frame-sync line is high, and data is taken on rising serial-clock edges. In frame-sync framing the frame opens on a falling edge of the active-low frame-sync line while the select is low, and data is taken on falling serial-clock edges. The serial clock idles low, and select edges only occur while it is low.

All port inputs are brought into the system clock domain through synchronizers and their edges are detected there. A single edge counter serves both framing styles. The capture window closes after the last bit of the word or when the select is released, whichever comes first. The top nibble of each word is the command code. A parameter mask marks which codes are configuration writes. Those codes carry a 12-bit payload in the low bits of the word. The block presents the decoded code, the payload and a one-cycle completion strobe, and it drives the output-enable for the converter's tri-state serial data output.

Top module: `sercmd_rx`

## Requirements
- R1: After reset, `sdo_oe_o`, `frame_done_o`, `cmd_code_o` and `cmd_data_o` are all zero.
- R2: `sdo_oe_o` goes to 1 after the select falls and returns to 0 after the select rises.
- R3: If the frame-sync line is high when the select falls, a frame starts and the data input is taken on each rising serial-clock edge, first bit = word bit 15.
- R4: If the frame-sync line is low when the select falls, nothing is captured (no strobe, no output change) until the frame-sync line falls. After that, data is taken on falling serial-clock edges, first bit = word bit 15.
- R5: A falling edge of the frame-sync line while the select is low resets the edge count and restarts the frame in frame-sync framing. Any bits already shifted are discarded.
- R6: Word bits 15:12 are the command code. `cmd_code_o` changes only in a cycle in which `frame_done_o` is 1.
- R7: For a code whose bit in `WR_CODE_MASK` is 0, `frame_done_o` pulses for one cycle once the fourth bit is taken, `cmd_code_o` takes the code, and `cmd_data_o` is unchanged.
- R8: For a code whose bit in `WR_CODE_MASK` is 1, `frame_done_o` pulses only once the sixteenth bit is taken. `cmd_code_o` takes the code and `cmd_data_o` takes word bits 11:0.
- R9: After the sixteenth bit, further serial-clock edges are ignored until the next select or frame-sync falling edge.
- R10: If the select rises before the strobing bit of a frame, no strobe occurs and `cmd_code_o` and `cmd_data_o` keep their previous values.
- R11: While the select is high, serial-clock and frame-sync activity produce no strobe.
- R12: `frame_done_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| cs_n_i | input | 1 | Active-low chip select |
| fs_n_i | input | 1 | Active-low frame sync, tied high when unused |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_oe_o | output | 1 | Output-enable for the tri-state serial data output |
| cmd_code_o | output | 4 | Last decoded command code |
| cmd_data_o | output | 12 | Last configuration-write payload |
| frame_done_o | output | 1 | One-cycle strobe when a command is complete |

## Verification
The bench builds the block with three synchronizer stages instead of two, so the edge-detection latency differs from the default. It also uses a write mask that marks codes 0x0, 0xA and 0xB as writes, which puts a write code at the bottom of the code space. The reference model is written in terms of the stage count, so a latency error shows up on the first mismatching cycle. The extra write code exercises the decision between the early and the late strobe at both ends of the code range.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

  // Capture state of the serial window
  typedef enum logic [2:0] {
    FR_IDLE    = 3'd0,  // select high
    FR_WAIT_FS = 3'd1,  // selected, waiting for frame-sync falling edge
    FR_SPI     = 3'd2,  // capturing on rising serial clock
    FR_DSP     = 3'd3,  // capturing on falling serial clock
    FR_CLOSED  = 3'd4   // word complete, window shut
  } frame_mode_e;

  // Edges seen on the synchronized port view
  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic cs_fall;
    logic fs_fall;
  } port_edges_t;

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sercmd_framer.sv
module sercmd_framer
  import sercmd_pkg::*;
#(
  parameter  int FRAME_BITS = 16,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             cs_n_s,
  input  logic             fs_n_s,
  input  logic             sdi_s,
  output logic             bit_stb_o,
  output logic             bit_val_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             sdo_oe_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic        sclk_q, cs_n_q, fs_n_q;
  port_edges_t ev;

  frame_mode_e      mode_q, mode_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             oe_q, oe_n;
  logic             mode_en;

  // previous-sample registers for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      fs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_n_q <= cs_n_s;
      fs_n_q <= fs_n_s;
    end
  end

  always_comb begin
    ev.sclk_rise = sclk_s & ~sclk_q;
    ev.sclk_fall = ~sclk_s & sclk_q;
    ev.cs_fall   = ~cs_n_s & cs_n_q;
    ev.fs_fall   = ~fs_n_s & fs_n_q;
  end

  // next-state logic
  always_comb begin
    mode_n    = mode_q;
    cnt_n     = cnt_q;
    bit_stb_o = 1'b0;
    if (cs_n_s) begin
      mode_n = FR_IDLE;
    end else if (ev.fs_fall) begin
      mode_n = FR_DSP;
      cnt_n  = '0;
    end else if (ev.cs_fall) begin
      mode_n = fs_n_s ? FR_SPI : FR_WAIT_FS;
      cnt_n  = '0;
    end else if ((mode_q == FR_SPI && ev.sclk_rise) ||
                 (mode_q == FR_DSP && ev.sclk_fall)) begin
      bit_stb_o = 1'b1;
      cnt_n     = cnt_q + ONE_CNT;
      if (cnt_n == FULL_CNT) mode_n = FR_CLOSED;
    end
    oe_n    = ~cs_n_s;
    mode_en = (mode_n != mode_q) || (cnt_n != cnt_q);
  end

  assign bit_val_o = sdi_s;
  assign bit_idx_o = cnt_n;
  assign sdo_oe_o  = oe_q;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FR_IDLE;
      cnt_q  <= '0;
    end else if (mode_en) begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_n;
  end

  // R9
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R2
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_s) |=> !sdo_oe_o);

  // R11
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !bit_stb_o);

  // R9
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FR_CLOSED && !ev.fs_fall) |-> !bit_stb_o);

endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder #(
  parameter  int                      FRAME_BITS  = 16,
  parameter  int                      CODE_BITS   = 4,
  parameter  logic [2**CODE_BITS-1:0] WR_MASK     = 16'h0C00,
  localparam int                      DATA_BITS   = FRAME_BITS - CODE_BITS,
  localparam int                      CNT_W       = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb_i,
  input  logic                 bit_val_i,
  input  logic [CNT_W-1:0]     bit_idx_i,
  output logic [CODE_BITS-1:0] code_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 done_o
);

  localparam logic [CNT_W-1:0] CODE_IDX = CNT_W'(CODE_BITS);
  localparam logic [CNT_W-1:0] FULL_IDX = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-2:0] sh_q, sh_n;
  logic [FRAME_BITS-1:0] word_now;
  logic [CODE_BITS-1:0]  code_early, code_full;
  logic [CODE_BITS-1:0]  code_q, code_n;
  logic [DATA_BITS-1:0]  data_q, data_n;
  logic                  done_q, done_n;
  logic                  out_en;

  assign word_now   = {sh_q, bit_val_i};
  assign code_early = word_now[CODE_BITS-1:0];
  assign code_full  = word_now[FRAME_BITS-1 -: CODE_BITS];

  always_comb begin
    sh_n   = bit_stb_i ? word_now[FRAME_BITS-2:0] : sh_q;
    done_n = 1'b0;
    code_n = code_q;
    data_n = data_q;
    out_en = 1'b0;
    if (bit_stb_i && bit_idx_i == CODE_IDX && !WR_MASK[code_early]) begin
      done_n = 1'b1;
      code_n = code_early;
      out_en = 1'b1;
    end
    if (bit_stb_i && bit_idx_i == FULL_IDX && WR_MASK[code_full]) begin
      done_n = 1'b1;
      code_n = code_full;
      data_n = word_now[DATA_BITS-1:0];
      out_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh_q <= '0;
    else if (bit_stb_i) sh_q <= sh_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      data_q <= '0;
    end else if (out_en) begin
      code_q <= code_n;
      data_q <= data_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign code_o = code_q;
  assign data_o = data_q;
  assign done_o = done_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));

  // R7
  data_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> (done_o && WR_MASK[code_o]));

endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx #(
  parameter int                      FRAME_BITS   = 16,
  parameter int                      CODE_BITS    = 4,
  parameter int                      SYNC_STAGES  = 2,
  parameter logic [2**CODE_BITS-1:0] WR_CODE_MASK = 16'h0C00
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk_i,
  input  logic                            cs_n_i,
  input  logic                            fs_n_i,
  input  logic                            sdi_i,
  output logic                            sdo_oe_o,
  output logic [CODE_BITS-1:0]            cmd_code_o,
  output logic [FRAME_BITS-CODE_BITS-1:0] cmd_data_o,
  output logic                            frame_done_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  // reset: asserted asynchronously, released synchronously
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // port synchronizers, order {sclk, cs_n, fs_n, sdi}
  logic [3:0] port_s;

  sercmd_sync #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({sclk_i, cs_n_i, fs_n_i, sdi_i}),
    .q_o   (port_s)
  );

  logic             bit_stb;
  logic             bit_val;
  logic [CNT_W-1:0] bit_idx;

  sercmd_framer #(
    .FRAME_BITS (FRAME_BITS)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sclk_s    (port_s[3]),
    .cs_n_s    (port_s[2]),
    .fs_n_s    (port_s[1]),
    .sdi_s     (port_s[0]),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .bit_idx_o (bit_idx),
    .sdo_oe_o  (sdo_oe_o)
  );

  sercmd_decoder #(
    .FRAME_BITS (FRAME_BITS),
    .CODE_BITS  (CODE_BITS),
    .WR_MASK    (WR_CODE_MASK)
  ) u_decoder (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .bit_idx_i (bit_idx),
    .code_o    (cmd_code_o),
    .data_o    (cmd_data_o),
    .done_o    (frame_done_o)
  );

  // R8
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frame_done_o && WR_CODE_MASK[cmd_code_o]) |-> $past(sdo_oe_o));

endmodule

// File: tb/tb_sercmd_rx.sv
module tb_sercmd_rx;

  localparam int          S    = 3;
  localparam logic [15:0] MASK = 16'h0C01;
  localparam int          HP   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, fs_n = 1'b1, sdi = 1'b0;
  logic        sdo_oe, done;
  logic [3:0]  code;
  logic [11:0] data;

  always #10 clk = ~clk;

  sercmd_rx #(
    .FRAME_BITS   (16),
    .CODE_BITS    (4),
    .SYNC_STAGES  (S),
    .WR_CODE_MASK (MASK)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_i       (sclk),
    .cs_n_i       (cs_n),
    .fs_n_i       (fs_n),
    .sdi_i        (sdi),
    .sdo_oe_o     (sdo_oe),
    .cmd_code_o   (code),
    .cmd_data_o   (data),
    .frame_done_o (done)
  );

  int n_chk = 0, n_fail = 0, n_done = 0;
  int last_code = 0, last_data = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 wait fs, 2 rise-capture, 3 fall-capture, 4 closed
  logic [3:0] hist[$];
  int  m_mode = 0, m_cnt = 0, m_word = 0, m_code = 0, m_data = 0;
  bit  m_oe = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < S + 2; i++) hist.push_back(4'b0110);
      m_mode = 0; m_cnt = 0; m_word = 0; m_code = 0; m_data = 0;
      m_oe = 0; m_done = 0;
    end else begin
      logic [3:0] c, p;
      hist.push_front({sclk, cs_n, fs_n, sdi});
      void'(hist.pop_back());
      c = hist[S];
      p = hist[S+1];
      m_done = 0;
      if (c[2]) m_mode = 0;
      else if (p[1] && !c[1]) begin m_mode = 3; m_cnt = 0; end
      else if (p[2] && !c[2]) begin m_mode = c[1] ? 2 : 1; m_cnt = 0; end
      else if ((m_mode == 2 && c[3] && !p[3]) || (m_mode == 3 && !c[3] && p[3])) begin
        m_word = ((m_word << 1) | c[0]) & 16'hFFFF;
        m_cnt++;
        if (m_cnt == 4 && !MASK[m_word & 15]) begin m_done = 1; m_code = m_word & 15; end
        if (m_cnt == 16) begin
          m_mode = 4;
          if (MASK[(m_word >> 12) & 15]) begin
            m_done = 1; m_code = (m_word >> 12) & 15; m_data = m_word & 12'hFFF;
          end
        end
      end
      m_oe = !c[2];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(sdo_oe == m_oe, "R2 oe", sdo_oe, m_oe);
      chk(done == m_done, "R7 strobe", done, m_done);
      chk(code == m_code[3:0], "R6 code", code, m_code);
      chk(data == m_data[11:0], "R8 data", data, m_data);
      if (done) begin
        n_done++;
        last_code = code;
        last_data = data;
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [31:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      logic b;
      b = w[nb-1-i];
      sdi = ~b; wclk(2);
      sdi = b;  wclk(2);
      sclk = 1'b1; wclk(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic dsp_bits(input logic [31:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      logic b;
      b = w[nb-1-i];
      sclk = 1'b1; sdi = ~b; wclk(2);
      sdi = b; wclk(2);
      sclk = 1'b0; wclk(HP);
    end
  endtask

  task automatic spi_frame(input logic [31:0] w, input int nb);
    fs_n = 1'b1; cs_n = 1'b0; wclk(HP);
    spi_bits(w, nb);
    wclk(HP); cs_n = 1'b1; wclk(12);
  endtask

  task automatic dsp_frame(input logic [31:0] w, input int nb, input int pre);
    fs_n = 1'b0; wclk(HP);
    cs_n = 1'b0; wclk(HP);
    for (int i = 0; i < pre; i++) begin
      sdi = 1'b1; sclk = 1'b1; wclk(HP); sclk = 1'b0; wclk(HP);
    end
    fs_n = 1'b1; wclk(HP);
    fs_n = 1'b0; wclk(HP);
    dsp_bits(w, nb);
    cs_n = 1'b1; fs_n = 1'b1; wclk(12);
  endtask

  initial begin
    int d0;
    wclk(3);
    // R1 reset values
    chk(sdo_oe == 0 && done == 0, "R1 oe/strobe", {sdo_oe, done}, 0);
    chk(code == 0 && data == 0, "R1 code/data", {code, data}, 0);
    rst_n = 1'b1;
    wclk(10);
    chk(sdo_oe == 0 && code == 0 && data == 0, "R1 after release", {sdo_oe, code, data}, 0);

    // R2 select drives output enable
    cs_n = 1'b0; wclk(10);
    chk(sdo_oe == 1, "R2 enable", sdo_oe, 1);
    cs_n = 1'b1; wclk(10);
    chk(sdo_oe == 0, "R2 release", sdo_oe, 0);

    // R3 / R7 rising-edge capture, read command
    d0 = n_done;
    spi_frame(32'h3ABC, 16);
    chk(n_done - d0 == 1, "R7 one strobe", n_done - d0, 1);
    chk(last_code == 3, "R3 code", last_code, 3);
    chk(data == 0, "R7 data kept", data, 0);

    // R8 write in select framing
    d0 = n_done;
    spi_frame(32'hA5C3, 16);
    chk(n_done - d0 == 1 && last_code == 'hA, "R8 write code", last_code, 'hA);
    chk(last_data == 'h5C3, "R8 write data", last_data, 'h5C3);

    // R4 frame-sync framing with ignored pre-clocks, write
    d0 = n_done;
    dsp_frame(32'hB123, 16, 5);
    chk(n_done - d0 == 1 && last_code == 'hB, "R4 code", last_code, 'hB);
    chk(last_data == 'h123, "R4 data", last_data, 'h123);

    // R4 / R7 frame-sync framing, read command
    d0 = n_done;
    dsp_frame(32'h7FFF, 16, 0);
    chk(n_done - d0 == 1 && last_code == 7, "R4 read code", last_code, 7);
    chk(data == 'h123, "R7 data kept", data, 'h123);

    // R10 aborted write
    d0 = n_done;
    spi_frame(32'h2AF, 10);
    chk(n_done == d0, "R10 no strobe", n_done - d0, 0);
    chk(code == 7 && data == 'h123, "R10 outputs kept", data, 'h123);

    // R9 extra edges after full word
    d0 = n_done;
    spi_frame(32'hA0F05, 20);
    chk(n_done - d0 == 1, "R9 single strobe", n_done - d0, 1);
    chk(data == 'h0F0, "R9 data", data, 'h0F0);

    // R5 frame-sync restart mid-frame
    d0 = n_done;
    fs_n = 1'b1; cs_n = 1'b0; wclk(HP);
    spi_bits(32'h2B, 6);
    wclk(HP); fs_n = 1'b0; wclk(HP);
    dsp_bits(32'hA777, 16);
    cs_n = 1'b1; fs_n = 1'b1; wclk(12);
    chk(n_done - d0 == 1, "R5 single strobe", n_done - d0, 1);
    chk(data == 'h777 && code == 'hA, "R5 data", data, 'h777);

    // R11 activity while deselected
    d0 = n_done;
    for (int i = 0; i < 20; i++) begin
      sdi = i[0]; sclk = 1'b1; wclk(HP); sclk = 1'b0; fs_n = i[1]; wclk(HP);
    end
    fs_n = 1'b1; wclk(12);
    chk(n_done == d0 && sdo_oe == 0, "R11 quiet", n_done - d0, 0);

    // R8 write code at bottom of code space
    spi_frame(32'h0FED, 16);
    chk(code == 0 && data == 'hFED, "R8 code zero write", data, 'hFED);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule